// File: doc/BRIEF.md
# Flash Busy-Status Read Generator

This block sits on the read path of an embedded flash controller. While the operation sequencer runs a program or erase, any host read returns a status pattern instead of array contents. One bit is a data-polling bit that shows whether the operation has completed. One bit flips on every read access. One bit is a sticky flag for an exceeded time limit. A separate ready line gives the same completion information in hardware.

When the sequencer drops its busy indication without a timeout, the block returns to plain array reads by itself and releases the operation parameters it captured. If the sequencer reports a timeout, the block stays in the status view even after busy falls. It leaves that view only when the host writes the return-to-read command.

The operation kind and the bit-7 value of the word being programmed are captured on the cycle the operation starts. All outputs are driven from registered state, so the data-polling bit and the ready line change in the same cycle.

Top module: `flash_status_flags`

## Requirements
- R1: Out of reset, `ready` is 1 and `rd_data` equals `arr_rdata`.
- R2: During a program operation, bit 7 of `rd_data` is the inverse of bit 7 of the data captured at the start of the operation.
- R3: During an erase operation (`op_erase`=1 at start), bit 7 of `rd_data` is 0.
- R4: Bit 6 of `rd_data` is cleared when an operation starts. It inverts once per rising edge of `host_rd` while the status view is active, so the first read shows 1 and the second shows 0. Holding `host_rd` high does not advance it again.
- R5: `op_timeout`, when seen during an operation, sets bit 5 of `rd_data`. The bit stays set, and the status view with `ready` low persists after `op_busy` falls, until the return-to-read command is accepted. Any other command write leaves it set.
- R6: The return-to-read command is a `host_wr` pulse with low byte 0xF0; the upper bits of `host_wdata` are ignored. Once accepted while the timeout flag is set, the next cycle shows `ready`=1 and array data.
- R7: `ready` is 0 from the cycle after `op_busy` rises until the cycle after `op_busy` falls (no timeout). In that cycle `ready` returns to 1 and `rd_data` returns to `arr_rdata`.
- R8: A command write during an operation without a timeout, including 0xF0, has no effect on `rd_data` or `ready`.
- R9: In the status view, every bit of `rd_data` other than bits 7, 6 and 5 is 0.
- R10: Changes to `op_data` or `op_erase` while an operation runs do not change `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_busy | input | 1 | Sequencer busy indication |
| op_erase | input | 1 | Operation kind: 1 erase, 0 program |
| op_data | input | DW | Data being programmed |
| op_timeout | input | 1 | Sequencer time-limit error pulse |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host command write strobe |
| host_wdata | input | DW | Host command data |
| arr_rdata | input | DW | Array read data |
| rd_data | output | DW | Data returned to the host |
| ready | output | 1 | 1 when ready, 0 when busy or halted on timeout |

## Verification
The bench builds the block with a 16-bit data width. This puts an upper byte above the status bits, which must read zero in the status view. The bench runs a program operation for all 256 values of the low data byte, with the upper byte varied. That covers both polarities of the polling bit and many patterns in the zero-filled bits. Erase operations, the timeout hold and its release, and commands written during busy periods are each exercised on the same configuration.

// File: rtl/stflag_pkg.sv
package stflag_pkg;
  localparam int POLL_BIT   = 7;
  localparam int TOGGLE_BIT = 6;
  localparam int ERROR_BIT  = 5;
  localparam int CMD_W      = 8;
  localparam logic [CMD_W-1:0] CMD_TO_READ = 8'hF0;

  typedef enum logic {OP_PROGRAM = 1'b0, OP_ERASE = 1'b1} op_kind_e;

  // polling bit shown while the operation is incomplete
  function automatic logic poll_value(op_kind_e kind, logic wr_bit7);
    return (kind == OP_ERASE) ? 1'b0 : ~wr_bit7;
  endfunction

  function automatic logic is_to_read(logic [CMD_W-1:0] cmd);
    return cmd == CMD_TO_READ;
  endfunction
endpackage

// File: rtl/stf_read_edge.sv
module stf_read_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= strobe;
  end

  assign rise = strobe & ~prev_q;
endmodule

// File: rtl/stf_op_track.sv
module stf_op_track
  import stflag_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     op_busy,
  input  logic     op_erase,
  input  logic     op_bit7,
  input  logic     op_timeout,
  input  logic     clr_err,
  output logic     act_q,
  output logic     err_q,
  output logic     start,
  output op_kind_e kind_q,
  output logic     bit7_q
);
  logic held;

  assign start = op_busy & ~act_q & ~err_q;
  assign held  = act_q | err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      err_q  <= 1'b0;
      kind_q <= OP_PROGRAM;
      bit7_q <= 1'b0;
    end else begin
      act_q <= op_busy;
      if (clr_err)                  err_q <= 1'b0;
      else if (op_timeout && act_q) err_q <= 1'b1;
      if (start) begin
        kind_q <= op_erase ? OP_ERASE : OP_PROGRAM;
        bit7_q <= op_bit7;
      end else if (!held) begin
        kind_q <= OP_PROGRAM;
        bit7_q <= 1'b0;
      end
    end
  end

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !clr_err |=> err_q);

  // R10
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q || err_q) && !start |=> (!(act_q || err_q) || (kind_q == $past(kind_q) && bit7_q == $past(bit7_q))));
endmodule

// File: rtl/stf_toggle.sv
module stf_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic adv,
  output logic tog_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tog_q <= 1'b0;
    else if (clear) tog_q <= 1'b0;
    else if (adv)   tog_q <= ~tog_q;
  end
endmodule

// File: rtl/flash_status_flags.sv
module flash_status_flags
  import stflag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_busy,
  input  logic          op_erase,
  input  logic [DW-1:0] op_data,
  input  logic          op_timeout,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] rd_data,
  output logic          ready
);
  localparam int CW = (DW < CMD_W) ? DW : CMD_W;

  logic          rd_rise;
  logic          act_q, err_q, start, bit7_q, tog_q;
  op_kind_e      kind_q;
  logic          stat_mode, cmd_accept, to_read_hit, tog_adv;
  logic [CMD_W-1:0] cmd_byte;
  logic [DW-1:0] status;

  always_comb begin
    cmd_byte = '0;
    cmd_byte[CW-1:0] = host_wdata[CW-1:0];
  end

  assign stat_mode   = act_q | err_q;
  // commands are ignored while an operation runs cleanly
  assign cmd_accept  = host_wr & (~act_q | err_q);
  assign to_read_hit = cmd_accept & is_to_read(cmd_byte);
  assign tog_adv     = rd_rise & stat_mode & ~start;

  stf_read_edge u_edge (
    .clk(clk), .rst_n(rst_n), .strobe(host_rd), .rise(rd_rise)
  );

  stf_op_track u_track (
    .clk(clk), .rst_n(rst_n), .op_busy(op_busy), .op_erase(op_erase),
    .op_bit7(op_data[POLL_BIT]), .op_timeout(op_timeout), .clr_err(to_read_hit),
    .act_q(act_q), .err_q(err_q), .start(start), .kind_q(kind_q), .bit7_q(bit7_q)
  );

  stf_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .clear(start), .adv(tog_adv), .tog_q(tog_q)
  );

  always_comb begin
    status             = '0;
    status[POLL_BIT]   = poll_value(kind_q, bit7_q);
    status[TOGGLE_BIT] = tog_q;
    status[ERROR_BIT]  = err_q;
  end

  assign rd_data = stat_mode ? status : arr_rdata;
  assign ready   = ~stat_mode;

  // R7
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> !ready);

  // R2
  prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q || err_q) && kind_q == OP_PROGRAM |-> rd_data[POLL_BIT] != bit7_q);

  // R3
  erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q || err_q) && kind_q == OP_ERASE |-> !rd_data[POLL_BIT]);

  // R4
  toggle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise && !ready && !start |=> (ready || rd_data[TOGGLE_BIT] != $past(rd_data[TOGGLE_BIT])));

  // R7
  ready_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> rd_data == arr_rdata);
endmodule

// File: tb/flash_status_flags_test.sv
module flash_status_flags_test;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_busy = 1'b0, op_erase = 1'b0, op_timeout = 1'b0;
  logic [DW-1:0] op_data = '0;
  logic          host_rd = 1'b0, host_wr = 1'b0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] arr_rdata = 16'hA5C3;
  logic [DW-1:0] rd_data;
  logic          ready;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_status_flags #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .op_busy(op_busy), .op_erase(op_erase),
    .op_data(op_data), .op_timeout(op_timeout), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .arr_rdata(arr_rdata),
    .rd_data(rd_data), .ready(ready)
  );

  function automatic logic [DW-1:0] expect_status(bit erase, logic [DW-1:0] d, int tog, int err);
    int poll;
    poll = erase ? 0 : (1 - int'(d[7]));
    return DW'(poll * 128 + tog * 64 + err * 32);
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_read(output logic [DW-1:0] v);
    host_rd = 1'b1; tick(); v = rd_data;
    host_rd = 1'b0; tick();
  endtask

  task automatic cmd(input logic [DW-1:0] w);
    host_wr = 1'b1; host_wdata = w; tick();
    host_wr = 1'b0; host_wdata = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v, d;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1; tick();
    // R1
    check("R1 ready", {15'b0, ready}, 16'd1);
    check("R1 data", rd_data, 16'hA5C3);

    // program sweep: R2 R4 R7 R8 R9 R10
    for (int i = 0; i < 256; i++) begin
      d = DW'(i) | DW'((i * 37 % 256) << 8);
      arr_rdata = ~d;
      op_busy = 1'b1; op_erase = 1'b0; op_data = d; tick();
      check("R7 ready low", {15'b0, ready}, 16'd0);
      check("R2 R9 status", rd_data, expect_status(0, d, 0, 0));
      do_read(v);
      check("R4 first read", v, expect_status(0, d, 1, 0));
      if (i % 16 == 0) begin
        host_rd = 1'b1; tick(); tick(); tick();
        check("R4 held strobe", rd_data, expect_status(0, d, 0, 0));
        host_rd = 1'b0; tick();
        op_data = ~d; op_erase = 1'b1; tick();
        check("R10 capture", rd_data, expect_status(0, d, 0, 0));
        cmd(16'h00F0); tick();
        check("R8 ignored", rd_data, expect_status(0, d, 0, 0));
        do_read(v);
        check("R4 after hold", v, expect_status(0, d, 1, 0));
      end
      do_read(v);
      arr_rdata = d;
      op_busy = 1'b0;
      check("R7 last busy", {15'b0, ready}, 16'd0);
      tick();
      check("R7 ready back", {15'b0, ready}, 16'd1);
      check("R7 array back", rd_data, d);
    end

    // erase: R3 R9
    for (int i = 0; i < 16; i++) begin
      d = DW'(i * 4099 + 128);
      op_busy = 1'b1; op_erase = 1'b1; op_data = d; tick();
      check("R3 erase poll", rd_data, expect_status(1, d, 0, 0));
      do_read(v);
      check("R3 R4 erase read", v, expect_status(1, d, 1, 0));
      op_busy = 1'b0; arr_rdata = DW'(16'hFFFF); tick();
      check("R7 erase done", rd_data, 16'hFFFF);
    end

    // timeout: R5 R6
    d = 16'h1234;
    op_busy = 1'b1; op_erase = 1'b0; op_data = d; tick();
    op_timeout = 1'b1; tick(); op_timeout = 1'b0;
    check("R5 flag", rd_data, expect_status(0, d, 0, 1));
    op_busy = 1'b0; tick(); tick();
    check("R5 held ready", {15'b0, ready}, 16'd0);
    do_read(v);
    check("R5 R4 read", v, expect_status(0, d, 1, 1));
    cmd(16'h00AA); tick();
    check("R5 other cmd", rd_data, expect_status(0, d, 1, 1));
    arr_rdata = 16'h5A5A;
    cmd(16'h7EF0);
    check("R6 ready", {15'b0, ready}, 16'd1);
    check("R6 array", rd_data, 16'h5A5A);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule